// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose pin controller for up to 32 pins. Every register holds one bit per pin, bit n belonging to pin n. Software sets each pin as an input or as a driven output and reads back the pin level. It can also arm each pin to raise an interrupt on a high or low level, on a rising or falling edge, or on any transition.

Pin inputs pass through a two-stage synchronizer. Edges are found by comparing the synchronized sample with the one before it. Detected events are latched in a status register and cleared by writing ones to a clear register. A pending view masks status with the enable register, and a single registered interrupt output is the OR of the pending bits. A read-only revision register reads 3, which tells software that any-transition detection is available.

The register bus is a plain 32-bit port: byte address, write strobe, write data and a read-data port that is registered one cycle after the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register (0x04) reads all ones (every pin an input), pin_oe is all zero, the enable register (0x08) and irq are zero, and the revision register (0x20) reads 3.
- R2: A direction bit of 0 drives pin_oe high for that pin, and pin_out carries the stored output bit written at offset 0x00.
- R3: A read of offset 0x00 returns the synchronized pin level for input pins and the stored output bit for output pins.
- R4: With the edge-select bit (0x18) set to 1 and the any-transition bit (0x24) clear, polarity bit (0x1C) 1 latches a rising edge and 0 latches a falling edge into status (0x0C); the opposite edge latches nothing.
- R5: With both the edge-select bit and the any-transition bit set, both edges are latched whatever the polarity bit holds.
- R6: With the edge-select bit at 0 the pin is level-sensitive: polarity 1 is active-high and 0 is active-low. After a clear, status reads 0 for one cycle and then sets again while the active level persists.
- R7: Writing 1 to a bit of the clear register (0x14) clears that status bit; 0 bits leave status unchanged.
- R8: An edge event in the same cycle as a clear of that bit leaves the status bit set.
- R9: The pending register (0x10) reads status AND enable, and irq is the OR of the pending bits one cycle later; irq stays low when no enabled pin has an event.
- R10: The enable register changes only by a bus write to 0x08, including when several pins fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output values to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge event that lands in the same clock cycle as a software clear of that bit. The bench changes a pin at a known falling clock edge and counts the two synchronizer stages and the compare stage. It then issues the clear write so that it is registered on the same edge that latches the event, and runs a control clear with no event to show that the clear works on its own. The one-cycle dip of a level-sensitive bit after a clear is caught by two back-to-back reads of the status register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    OFF_VAL  = 6'h00,
    OFF_DIR  = 6'h04,
    OFF_IEN  = 6'h08,
    OFF_RAW  = 6'h0C,
    OFF_PEND = 6'h10,
    OFF_ACK  = 6'h14,
    OFF_EDGE = 6'h18,
    OFF_POL  = 6'h1C,
    OFF_REV  = 6'h20,
    OFF_ANY  = 6'h24
  } reg_off_e;

  localparam logic [BUS_W-1:0] REV_ID = 32'd3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol_sel,
  input  logic [W-1:0] any_sel,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise = smp[i] & ~prev_q[i];
      assign fall = ~smp[i] & prev_q[i];
      always_comb begin
        if (edge_sel[i]) begin
          if (any_sel[i]) evt[i] = rise | fall;
          else            evt[i] = pol_sel[i] ? rise : fall;
        end else begin
          evt[i] = pol_sel[i] ? smp[i] : ~smp[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] out_q, dir_q, ien_q, raw_q, edge_q, pol_q, any_q;
  logic [NPINS-1:0] smp, evt, wdat, clr_mask, raw_nxt, pend, val_view;

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    return BUS_W'(v);
  endfunction

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(smp)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .smp(smp), .edge_sel(edge_q),
    .pol_sel(pol_q), .any_sel(any_q), .evt(evt)
  );

  assign wdat     = bus_wdata[NPINS-1:0];
  assign clr_mask = (bus_wr && bus_addr == OFF_ACK) ? wdat : '0;
  // edge events win over a coincident clear; level events wait one cycle
  assign raw_nxt  = (raw_q & ~clr_mask) | (evt & (edge_q | ~clr_mask));
  assign pend     = raw_q & ien_q;
  assign val_view = (dir_q & smp) | (~dir_q & out_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '1;
      ien_q  <= '0;
      raw_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_VAL)  out_q  <= wdat;
      if (bus_wr && bus_addr == OFF_DIR)  dir_q  <= wdat;
      if (bus_wr && bus_addr == OFF_IEN)  ien_q  <= wdat;
      if (bus_wr && bus_addr == OFF_EDGE) edge_q <= wdat;
      if (bus_wr && bus_addr == OFF_POL)  pol_q  <= wdat;
      if (bus_wr && bus_addr == OFF_ANY)  any_q  <= wdat;
      raw_q <= raw_nxt;
      irq   <= |pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFF_VAL:  bus_rdata <= widen(val_view);
        OFF_DIR:  bus_rdata <= widen(dir_q);
        OFF_IEN:  bus_rdata <= widen(ien_q);
        OFF_RAW:  bus_rdata <= widen(raw_q);
        OFF_PEND: bus_rdata <= widen(pend);
        OFF_EDGE: bus_rdata <= widen(edge_q);
        OFF_POL:  bus_rdata <= widen(pol_q);
        OFF_ANY:  bus_rdata <= widen(any_q);
        OFF_REV:  bus_rdata <= REV_ID;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  AST_RESET_OE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && !irq)); // R1

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((raw_q & $past(evt & ~clr_mask)) == $past(evt & ~clr_mask))); // R4

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_ACK) |=> ((raw_q & $past(wdat & ~evt)) == '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq); // R9

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFF_IEN) |=> $stable(ien_q)); // R10
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NP = 32;
  localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08,
    A_RAW = 6'h0C, A_PEND = 6'h10, A_ACK = 6'h14, A_EDGE = 6'h18,
    A_POL = 6'h1C, A_REV = 6'h20, A_ANY = 6'h24;
  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb_q[$];

  gpio_irq_ctrl #(.NPINS(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #10 clk = ~clk;

  // monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_OUT:   act = pin_out;
        K_OE:    act = pin_oe;
        default: act = {31'd0, irq};
      endcase
      n_run++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e,
                    input logic [31:0] m, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    sb_q.push_back('{K_RD, e, m, tag});
  endtask

  task automatic chk(input int k, input logic [31:0] e, input string tag);
    @(posedge clk);
    sb_q.push_back('{k, e, 32'hFFFF_FFFF, tag});
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(A_DIR, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 dir reset");
    rd(A_IEN, 32'h0, 32'hFFFF_FFFF, "R1 enable reset");
    rd(A_REV, 32'd3, 32'hFFFF_FFFF, "R1 revision");
    chk(K_OE, 32'h0, "R1 pin_oe reset");
    chk(K_IRQ, 32'h0, "R1 irq reset");

    // R2 / R3 outputs and readback
    wr(A_DIR, 32'hFFFF_0000);
    wr(A_VAL, 32'h0000_A5C3);
    chk(K_OUT, 32'h0000_A5C3, "R2 pin_out");
    chk(K_OE, 32'h0000_FFFF, "R2 pin_oe");
    set_pins(32'h1234_FFFF);
    idle(4);
    rd(A_VAL, 32'h1234_A5C3, 32'hFFFF_FFFF, "R3 value mixed");
    set_pins(32'h0);
    wr(A_DIR, 32'hFFFF_FFFF);
    idle(4);

    // R4 rising edge on pin 3
    wr(A_EDGE, 32'hFFFF_FFFF);
    wr(A_POL, 32'hFFFF_FFFF);
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_IEN, 32'h8);
    rd(A_RAW, 32'h0, 32'hFFFF_FFFF, "R7 all cleared");
    set_pins(32'h8);
    idle(5);
    rd(A_RAW, 32'h8, 32'h8, "R4 rising latched");
    rd(A_PEND, 32'h8, 32'hFFFF_FFFF, "R9 pending");
    chk(K_IRQ, 32'h1, "R9 irq high");
    wr(A_ACK, 32'h8);
    set_pins(32'h0);
    idle(5);
    rd(A_RAW, 32'h0, 32'h8, "R4 falling ignored in rising mode");
    chk(K_IRQ, 32'h0, "R7 irq low after clear");

    // R4 falling edge on pin 5
    wr(A_POL, ~32'h20);
    set_pins(32'h20);
    idle(5);
    rd(A_RAW, 32'h0, 32'h20, "R4 rise ignored in falling mode");
    set_pins(32'h0);
    idle(5);
    rd(A_RAW, 32'h20, 32'h20, "R4 falling latched");
    chk(K_IRQ, 32'h0, "R9 masked event keeps irq low");
    wr(A_ACK, 32'h20);

    // R5 any-transition on pin 0, polarity 0
    wr(A_ANY, 32'h1);
    wr(A_POL, ~32'h21);
    set_pins(32'h1);
    idle(5);
    rd(A_RAW, 32'h1, 32'h1, "R5 rise latched");
    wr(A_ACK, 32'h1);
    rd(A_RAW, 32'h0, 32'h1, "R7 clear pin0");
    set_pins(32'h0);
    idle(5);
    rd(A_RAW, 32'h1, 32'h1, "R5 fall latched");

    // R7 zero writes have no effect
    wr(A_ACK, 32'h0);
    rd(A_RAW, 32'h1, 32'h1, "R7 zero write ignored");

    // R8 edge coinciding with clear
    wr(A_ACK, 32'h1);
    set_pins(32'h1);
    @(posedge clk);
    @(posedge clk);
    wr(A_ACK, 32'h1);
    rd(A_RAW, 32'h1, 32'h1, "R8 edge wins over clear");
    idle(3);
    wr(A_ACK, 32'h1);
    rd(A_RAW, 32'h0, 32'h1, "R8 control clear without edge");

    // R6 level-high on pin 7
    wr(A_EDGE, ~32'h80);
    set_pins(32'h81);
    idle(5);
    rd(A_RAW, 32'h80, 32'h80, "R6 level high latched");
    wr(A_ACK, 32'h80);
    rd(A_RAW, 32'h0, 32'h80, "R6 dip after clear");
    rd(A_RAW, 32'h80, 32'h80, "R6 re-set while active");
    set_pins(32'h1);
    idle(4);
    wr(A_ACK, 32'h80);
    idle(2);
    rd(A_RAW, 32'h0, 32'h80, "R6 stays clear when inactive");

    // R6 level-low on pin 9
    wr(A_POL, ~32'h221);
    wr(A_EDGE, ~32'h280);
    idle(3);
    rd(A_RAW, 32'h200, 32'h200, "R6 level low latched");

    // R10 several pins at once
    wr(A_IEN, 32'h16);
    set_pins(32'h17);
    idle(5);
    rd(A_IEN, 32'h16, 32'hFFFF_FFFF, "R10 enable intact");
    rd(A_PEND, 32'h16, 32'hFFFF_FFFF, "R9 pending multi");
    chk(K_IRQ, 32'h1, "R9 irq multi");

    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule